// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the six base address slots of a PCI Express function's type-0 configuration header (dword offsets 0x10 through 0x24) together with the 16-bit command register at offset 0x04. Each slot is configured at elaboration time as absent, an I/O window, a 32-bit memory window or a 64-bit memory window. Each window has an optional prefetchable flag and a power-of-two size of at least 16 bytes. Software reaches the registers through a dword-wide configuration port with byte enables. It sizes a window by writing all ones and reading back the mask, then writes the base.

In operation, every request address is compared with all live windows. The comparison is gated by the space-enable bits of the command register and by the request type. One clock later the block reports whether a window matched, which slot matched, and the byte offset of the request inside that window. A 64-bit window takes two consecutive slots. The second slot holds the upper address dword and is never matched as a window of its own.

Top module: `bar_decode_bank`

## Requirements
- R1: Address bits below log2(size) of a window read as zero and ignore writes. After all ones are written, a 4 KB 32-bit memory slot reads 0xFFFFF000 and a 1 MB slot reads 0xFFF00000.
- R2: The low type bits of a slot are read-only. An I/O slot reads bit 0 = 1. A memory slot reads bit 0 = 0, bits [2:1] = 00 for 32-bit or 10 for 64-bit, and bit 3 = prefetchable. After all ones are written, a 32-byte I/O slot reads 0xFFFFFFE1.
- R3: A 64-bit window uses its slot for the low dword and the next slot (offset +4) for the high dword. With a size of 4 GB or more, the low dword has no writable address bits: a prefetchable 4 GB slot reads 0x0000000C. The size mask then lies in the high dword, which reads 0xFFFFFFFF after all ones are written.
- R4: A request matches a window when its address ANDed with the window's 64-bit size mask equals the base, the base being the slot value with its low four bits cleared. For 32-bit windows the upper 32 address bits must be zero. hit, hit_bar and hit_offset (address with the mask bits cleared) appear one clock after the request is sampled, and they are zero when nothing matches.
- R5: Memory windows match only memory requests (req_is_io = 0) and only while command bit 1 is set. I/O windows match only I/O requests and only while command bit 0 is set. Each enable bit acts on all windows of its type.
- R6: The command register (dword index 1) is 16 bits. Byte enables 0 and 1 write its two bytes, byte enables 2 and 3 are ignored, and the upper halfword reads zero.
- R7: When several windows match, the lowest slot index is reported.
- R8: Absent slots, the high-dword slot of a 64-bit window (as a window), and all other dword indices read zero or are never matched. Writes to absent slots and to other indices have no effect.
- R9: Rewriting the base of an enabled window moves the match from the old range to the new range from the next request on.
- R10: After reset, all address bits of all slots and the command register are zero, and hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 10 | Configuration dword index (byte offset bits 11:2) |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_dw (combinational) |
| req_valid | input | 1 | Request address is valid |
| req_is_io | input | 1 | Request targets I/O space (else memory) |
| req_addr | input | 64 | Request address |
| hit | output | 1 | Registered: a window matched |
| hit_bar | output | 3 | Registered: slot index of the matching window |
| hit_offset | output | 64 | Registered: byte offset inside the matching window |

## Verification
The bench builds the default parameter set, which places every slot kind in one instance. Slot 0 is a prefetchable 4 GB 64-bit window, so its mask lives entirely in the high dword and slot 1 serves as its upper half. Slot 2 is a 4 KB memory window and slot 4 a 1 MB memory window; the two can be programmed to overlap, which makes the lowest-index rule observable. Slot 3 is a 32-byte I/O window and slot 5 is absent. With this mix, the enable gating, the request-type filter, the zero-upper-address rule of 32-bit windows and the read-only holes can all be reached from the ports.

// File: rtl/bar_bank_pkg.sv
// Shared types and helpers for the base address window decoder.
// Assumes window sizes are powers of two between 2^4 and 2^63 bytes.
package bar_bank_pkg;

    typedef enum logic [1:0] {
        BAR_NONE  = 2'd0,
        BAR_IO    = 2'd1,
        BAR_MEM32 = 2'd2,
        BAR_MEM64 = 2'd3
    } bar_kind_e;

    localparam int unsigned NUM_SLOTS   = 6;   // slots at dword 4..9
    localparam int unsigned SLOT_BASE_DW = 4;  // dword index of first slot
    localparam int unsigned CMD_DW      = 1;   // dword index of command
    localparam int unsigned CMD_W       = 16;
    localparam int unsigned CMD_IO_BIT  = 0;
    localparam int unsigned CMD_MEM_BIT = 1;
    localparam int unsigned REQ_AW      = 64;
    localparam int unsigned SLOT_IW     = $clog2(NUM_SLOTS);
    localparam int unsigned DW_IDX_W    = 10;

    // Writable address bits of the low dword of a window.
    function automatic logic [31:0] lo_mask_f(bar_kind_e k, int unsigned lg);
        if (k == BAR_NONE || lg >= 32) return 32'h0;
        return 32'hFFFF_FFFF << lg;
    endfunction

    // Writable address bits of the high dword (64-bit windows only).
    function automatic logic [31:0] hi_mask_f(bar_kind_e k, int unsigned lg);
        if (k != BAR_MEM64) return 32'h0;
        if (lg >= 32) return 32'hFFFF_FFFF << (lg - 32);
        return 32'hFFFF_FFFF;
    endfunction

    // Read-only type bits in the low nibble.
    function automatic logic [31:0] type_bits_f(bar_kind_e k, bit pref);
        case (k)
            BAR_IO:    return 32'h1;
            BAR_MEM32: return {28'h0, pref, 3'b000};
            BAR_MEM64: return {28'h0, pref, 3'b100};
            default:   return 32'h0;
        endcase
    endfunction

    // Byte-enable merge of new data into an old dword.
    function automatic logic [31:0] be_merge_f(logic [31:0] old_v, logic [31:0] new_v,
                                               logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/bar_slot.sv
// One base address window: low dword and, for 64-bit windows, high dword.
// Applies the size masks on write, supplies read data with type bits and
// exports the 64-bit base and mask used by the matcher.
// Assumes LOG2 >= 4 so the type nibble never overlaps address bits.
module bar_slot
    import bar_bank_pkg::*;
#(
    parameter bar_kind_e   KIND = BAR_MEM32,
    parameter bit          PREF = 1'b0,
    parameter int unsigned LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi,
    output logic [63:0] win_base,
    output logic [63:0] win_mask
);
    localparam logic [31:0] LO_MASK     = lo_mask_f(KIND, LOG2);
    localparam logic [31:0] HI_MASK     = hi_mask_f(KIND, LOG2);
    localparam logic [31:0] TYPE_BITS   = type_bits_f(KIND, PREF);
    localparam logic [31:0] DEC_HI_MASK = (KIND == BAR_MEM64) ? HI_MASK : 32'hFFFF_FFFF;

    logic [31:0] lo_q;
    logic [31:0] hi_q;

    // Store programmed address bits, dropping those below the window size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= be_merge_f(lo_q, wdata, be) & LO_MASK;
            if (wr_hi) hi_q <= be_merge_f(hi_q, wdata, be) & HI_MASK;
        end
    end

    // Read data and decode window.
    always_comb begin
        rd_lo    = lo_q | TYPE_BITS;
        rd_hi    = hi_q;
        win_base = {hi_q, lo_q};
        win_mask = {DEC_HI_MASK, LO_MASK};
    end

    // R1: no address bit below the window size is ever held
    p_lo_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q & ~LO_MASK) == 32'h0);

    // R3: high dword keeps only the bits of its size mask
    p_hi_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q & ~HI_MASK) == 32'h0);

endmodule

// File: rtl/bar_match.sv
// Compares one request with every live window, gated by the space enables
// and request type, picks the lowest matching slot and registers the result.
// Assumes window bases have no bits set outside their masks.
module bar_match
    import bar_bank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS-1:0]          slot_live,
    input  logic [NUM_SLOTS-1:0]          slot_io,
    input  logic [NUM_SLOTS-1:0][63:0]    win_base,
    input  logic [NUM_SLOTS-1:0][63:0]    win_mask,
    input  logic                          en_io,
    input  logic                          en_mem,
    input  logic                          req_valid,
    input  logic                          req_is_io,
    input  logic [REQ_AW-1:0]             req_addr,
    output logic                          hit,
    output logic [SLOT_IW-1:0]            hit_bar,
    output logic [REQ_AW-1:0]             hit_offset
);
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [SLOT_IW-1:0]   pick;
    logic [REQ_AW-1:0]    pick_off;

    // Per-slot match under enables and request type.
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            hit_vec[i] = req_valid && slot_live[i] && (slot_io[i] == req_is_io)
                      && (slot_io[i] ? en_io : en_mem)
                      && ((req_addr & win_mask[i]) == win_base[i]);
        end
    end

    // Lowest index wins: scan from the top so lower slots overwrite.
    always_comb begin
        pick     = '0;
        pick_off = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                pick     = SLOT_IW'(i);
                pick_off = req_addr & ~win_mask[i];
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit        <= 1'b0;
            hit_bar    <= '0;
            hit_offset <= '0;
        end else begin
            hit        <= |hit_vec;
            hit_bar    <= pick;
            hit_offset <= pick_off;
        end
    end

    // R4: a hit always follows a valid request
    p_hit_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(req_valid));

    // R5: a hit requires the enable of the request's space
    p_space_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(req_is_io ? en_io : en_mem));

    // R8: only live slots are ever reported
    p_live_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> slot_live[hit_bar]);

    // R7: no lower slot matched the reported request
    p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (($past(hit_vec) & ((NUM_SLOTS'(1) << hit_bar) - NUM_SLOTS'(1))) == '0));

endmodule

// File: rtl/bar_decode_bank.sv
// Base address window decoder: command register, six configurable slots at
// dword 4..9, configuration read mux and registered request decode.
// Assumes the slot after a 64-bit window exists and is configured BAR_NONE.
module bar_decode_bank
    import bar_bank_pkg::*;
#(
    parameter bar_kind_e   BAR_KIND [NUM_SLOTS] = '{BAR_MEM64, BAR_NONE, BAR_MEM32,
                                                     BAR_IO, BAR_MEM32, BAR_NONE},
    parameter bit          BAR_PREF [NUM_SLOTS] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    parameter int unsigned BAR_LOG2 [NUM_SLOTS] = '{32, 4, 12, 5, 20, 4}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [11:2]          cfg_dw,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 req_valid,
    input  logic                 req_is_io,
    input  logic [REQ_AW-1:0]    req_addr,
    output logic                 hit,
    output logic [SLOT_IW-1:0]   hit_bar,
    output logic [REQ_AW-1:0]    hit_offset
);
    logic [CMD_W-1:0]                cmd_q;
    logic [31:0]                     cmd_merge;
    logic [NUM_SLOTS-1:0]            slot_live;
    logic [NUM_SLOTS-1:0]            slot_io;
    logic [NUM_SLOTS-1:0][31:0]      slot_rd;
    logic [NUM_SLOTS-1:0][31:0]      hi_rd;
    logic [NUM_SLOTS-1:0][63:0]      win_base;
    logic [NUM_SLOTS-1:0][63:0]      win_mask;

    // Command merge: only the low halfword's byte enables take part.
    always_comb cmd_merge = be_merge_f({16'h0, cmd_q}, cfg_wdata, {2'b00, cfg_be[1:0]});

    // Command register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (cfg_we && cfg_dw == DW_IDX_W'(CMD_DW))
            cmd_q <= cmd_merge[CMD_W-1:0];
    end

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
        localparam bit PREV64 = (gi > 0) && (BAR_KIND[(gi > 0) ? gi - 1 : 0] == BAR_MEM64);
        localparam bit LIVE   = (BAR_KIND[gi] != BAR_NONE) && !PREV64;

        assign slot_live[gi] = LIVE;
        assign slot_io[gi]   = (BAR_KIND[gi] == BAR_IO);

        if (LIVE) begin : g_bar
            logic wr_lo;
            logic wr_hi;
            assign wr_lo = cfg_we && (cfg_dw == DW_IDX_W'(SLOT_BASE_DW + gi));
            assign wr_hi = cfg_we && (BAR_KIND[gi] == BAR_MEM64)
                        && (cfg_dw == DW_IDX_W'(SLOT_BASE_DW + gi + 1));
            bar_slot #(
                .KIND (BAR_KIND[gi]),
                .PREF (BAR_PREF[gi]),
                .LOG2 (BAR_LOG2[gi])
            ) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_lo    (wr_lo),
                .wr_hi    (wr_hi),
                .be       (cfg_be),
                .wdata    (cfg_wdata),
                .rd_lo    (slot_rd[gi]),
                .rd_hi    (hi_rd[gi]),
                .win_base (win_base[gi]),
                .win_mask (win_mask[gi])
            );
        end else begin : g_hole
            assign hi_rd[gi]    = 32'h0;
            assign win_base[gi] = 64'h0;
            assign win_mask[gi] = 64'h0;
            if (PREV64) begin : g_upper
                assign slot_rd[gi] = hi_rd[gi - 1];
            end else begin : g_empty
                assign slot_rd[gi] = 32'h0;
            end
        end
    end

    // Configuration read mux; unlisted indices read zero.
    always_comb begin
        cfg_rdata = 32'h0;
        if (cfg_dw == DW_IDX_W'(CMD_DW))
            cfg_rdata = {16'h0, cmd_q};
        for (int i = 0; i < NUM_SLOTS; i++)
            if (cfg_dw == DW_IDX_W'(SLOT_BASE_DW + i))
                cfg_rdata = slot_rd[i];
    end

    bar_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_live  (slot_live),
        .slot_io    (slot_io),
        .win_base   (win_base),
        .win_mask   (win_mask),
        .en_io      (cmd_q[CMD_IO_BIT]),
        .en_mem     (cmd_q[CMD_MEM_BIT]),
        .req_valid  (req_valid),
        .req_is_io  (req_is_io),
        .req_addr   (req_addr),
        .hit        (hit),
        .hit_bar    (hit_bar),
        .hit_offset (hit_offset)
    );

    // R6: writes without low byte enables leave the command register alone
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_dw == DW_IDX_W'(CMD_DW) && cfg_be[1:0] == 2'b00) |=> $stable(cmd_q));

    // R8: reads of indices outside the command and slot range return zero
    p_hole_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw != DW_IDX_W'(CMD_DW) && (cfg_dw < DW_IDX_W'(SLOT_BASE_DW)
         || cfg_dw >= DW_IDX_W'(SLOT_BASE_DW + NUM_SLOTS))) |-> cfg_rdata == 32'h0);

endmodule

// File: tb/tb_bar_decode_bank.sv
module tb_bar_decode_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:2] cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic        hit;
    logic [2:0]  hit_bar;
    logic [63:0] hit_offset;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench view of the default configuration: 0 none, 1 io, 2 mem32, 3 mem64.
    int          kd [6] = '{3, 0, 2, 1, 2, 0};
    bit          pf [6] = '{1, 0, 0, 0, 0, 0};
    int          lg [6] = '{32, 4, 12, 5, 20, 4};
    logic [31:0] m_lo [6];
    logic [31:0] m_hi [6];
    logic [15:0] m_cmd;

    always #2 clk = ~clk;

    bar_decode_bank dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit), .hit_bar(hit_bar),
        .hit_offset(hit_offset)
    );

    function automatic bit is_upper(int s);
        return (s > 0) && (kd[s-1] == 3);
    endfunction

    function automatic logic [31:0] mlo(int s);
        if (kd[s] == 0 || is_upper(s) || lg[s] >= 32) return 32'h0;
        return 32'hFFFF_FFFF << lg[s];
    endfunction

    function automatic logic [31:0] mhi(int s);
        if (kd[s] != 3) return 32'h0;
        if (lg[s] >= 32) return 32'hFFFF_FFFF << (lg[s] - 32);
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] tbits(int s);
        if (is_upper(s)) return 32'h0;
        case (kd[s])
            1: return 32'h1;
            2: return pf[s] ? 32'h8 : 32'h0;
            3: return pf[s] ? 32'hC : 32'h4;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] b);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = b[k] ? n[k*8 +: 8] : o[k*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(int idx);
        int s;
        if (idx == 1) return {16'h0, m_cmd};
        if (idx < 4 || idx > 9) return 32'h0;
        s = idx - 4;
        if (is_upper(s)) return m_hi[s-1];
        if (kd[s] == 0) return 32'h0;
        return m_lo[s] | tbits(s);
    endfunction

    function automatic logic [63:0] wmask(int s);
        return {(kd[s] == 3) ? mhi(s) : 32'hFFFF_FFFF, mlo(s)};
    endfunction

    function automatic logic [63:0] wbase(int s);
        return {(kd[s] == 3) ? m_hi[s] : 32'h0, m_lo[s]};
    endfunction

    task automatic model_dec(input logic [63:0] a, input bit io, output bit h,
                             output int b, output logic [63:0] off);
        h = 0; b = 0; off = '0;
        for (int s = 5; s >= 0; s--) begin
            bit sio;
            sio = (kd[s] == 1);
            if (kd[s] != 0 && !is_upper(s) && sio == io
                && (sio ? m_cmd[0] : m_cmd[1]) && ((a & wmask(s)) == wbase(s))) begin
                h = 1; b = s; off = a & ~wmask(s);
            end
        end
    endtask

    task automatic cfg_wr(input int idx, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw = 10'(idx); cfg_wdata = d; cfg_be = b;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        if (idx == 1) m_cmd = merge({16'h0, m_cmd}, d, {2'b00, b[1:0]}) & 32'hFFFF;
        else if (idx >= 4 && idx <= 9) begin
            int s;
            s = idx - 4;
            if (is_upper(s)) m_hi[s-1] = merge(m_hi[s-1], d, b) & mhi(s-1);
            else if (kd[s] != 0) m_lo[s] = merge(m_lo[s], d, b) & mlo(s);
        end
    endtask

    task automatic chk_rd(input string rq, input int idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_dw = 10'(idx);
        #1;
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: read dword %0d got %h expected %h", rq, idx, cfg_rdata, exp);
        end
    endtask

    task automatic chk_dec(input string rq, input logic [63:0] a, input bit io,
                           input bit eh, input int eb, input logic [63:0] eo);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io;
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (hit !== eh || (eh && (hit_bar !== 3'(eb) || hit_offset !== eo))
            || (!eh && (hit_bar !== 3'd0 || hit_offset !== 64'h0))) begin
            n_fail++;
            $display("FAIL %s: addr %h io %0d got hit=%0d bar=%0d off=%h expected hit=%0d bar=%0d off=%h",
                     rq, a, io, hit, hit_bar, hit_offset, eh, eb, eo);
        end
    endtask

    task automatic chk_model(input string rq, input logic [63:0] a, input bit io);
        bit h; int b; logic [63:0] o;
        model_dec(a, io, h, b, o);
        chk_dec(rq, a, io, h, b, o);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        for (int s = 0; s < 6; s++) begin m_lo[s] = '0; m_hi[s] = '0; end
        m_cmd = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        @(negedge clk);
        n_chk++;
        if (hit !== 1'b0) begin n_fail++; $display("FAIL R10: hit got %0d expected 0", hit); end
        for (int i = 0; i < 12; i++) chk_rd("R10", i, exp_read(i));
        chk_rd("R10", 4, 32'h0000000C);
        chk_rd("R10", 7, 32'h00000001);

        // R1 R2 R3 R8: sizing with all ones
        for (int i = 4; i < 10; i++) cfg_wr(i, 32'hFFFF_FFFF, 4'hF);
        chk_rd("R3", 4, 32'h0000000C);
        chk_rd("R3", 5, 32'hFFFF_FFFF);
        chk_rd("R1", 6, 32'hFFFF_F000);
        chk_rd("R2", 7, 32'hFFFF_FFE1);
        chk_rd("R1", 8, 32'hFFF0_0000);
        chk_rd("R8", 9, 32'h0);
        cfg_wr(0, 32'hFFFF_FFFF, 4'hF);
        chk_rd("R8", 0, 32'h0);

        // program bases
        cfg_wr(4, 32'h0, 4'hF);
        cfg_wr(5, 32'h2, 4'hF);
        cfg_wr(6, 32'h8000_1FFF, 4'hF);
        chk_rd("R1", 6, 32'h8000_1000);
        cfg_wr(7, 32'h0000_1000, 4'hF);
        cfg_wr(8, 32'h8000_0000, 4'hF);

        // R5: all spaces disabled
        chk_dec("R5", 64'h8000_1010, 0, 0, 0, 0);
        cfg_wr(1, 32'h2, 4'hF);
        chk_dec("R7", 64'h8000_1010, 0, 1, 2, 64'h10);
        chk_dec("R4", 64'h8000_2000, 0, 1, 4, 64'h2000);
        chk_dec("R5", 64'h1004, 1, 0, 0, 0);
        chk_dec("R5", 64'h1004, 0, 0, 0, 0);
        chk_dec("R3", 64'h2_1234_5678, 0, 1, 0, 64'h1234_5678);
        chk_dec("R3", 64'h3_0000_0000, 0, 0, 0, 0);
        chk_dec("R4", 64'h1_8000_1000, 0, 0, 0, 0);
        cfg_wr(1, 32'h1, 4'h1);
        chk_dec("R5", 64'h1004, 1, 1, 3, 64'h4);
        chk_dec("R5", 64'h8000_1010, 0, 0, 0, 0);

        // R9: move slot 2 while enabled
        cfg_wr(1, 32'h3, 4'h1);
        cfg_wr(6, 32'h9000_0000, 4'hF);
        chk_dec("R9", 64'h8000_1010, 0, 1, 4, 64'h1010);
        chk_dec("R9", 64'h9000_0020, 0, 1, 2, 64'h20);

        // R6: command byte enables and width
        cfg_wr(1, 32'h0, 4'b1100);
        chk_rd("R6", 1, 32'h3);
        cfg_wr(1, 32'hFFFF_FFFF, 4'hF);
        chk_rd("R6", 1, 32'h0000_FFFF);
        cfg_wr(1, 32'h0000_0003, 4'b0001);
        chk_rd("R6", 1, 32'h0000_FF03);

        // mixed random traffic checked against the bench model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                int idx;
                idx = int'($urandom % 12);
                cfg_wr(idx, $urandom, 4'($urandom));
                chk_rd("R1 R8 random write", idx, exp_read(idx));
            end else if (op == 3) begin
                int idx;
                idx = int'($urandom % 12);
                chk_rd("R2 random read", idx, exp_read(idx));
            end else begin
                int s;
                logic [63:0] a;
                bit io;
                case ($urandom % 4)
                    0: s = 0; 1: s = 2; 2: s = 3; default: s = 4;
                endcase
                a = wbase(s) | ({$urandom, $urandom} & ~wmask(s));
                if ($urandom % 4 == 0) a = {$urandom % 4, $urandom};
                io = (kd[s] == 1);
                if ($urandom % 5 == 0) io = ~io;
                chk_model("R4 R5 R7 random decode", a, io);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R): got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule